// File: doc/BRIEF.md
# Keypress Event FIFO Recorder

This block turns an already debounced and decoded key stream into a queue of timed records. An upstream decoder presents an 8-bit code together with a one-cycle valid strobe whenever the key state changes. A press carries the key's own code, and a release carries a reserved release code, which defaults to 0x00. A free-running timebase tick drives a 7-bit duration counter. On every recorded event, the block pushes a two-byte record into an eight-entry FIFO. The record holds the event code and the number of ticks since the previous event, which is the length of the press or idle interval that the event ends. The counter then restarts.

A host reaches the block through a small byte-wide register port with four addresses:

- a control/status byte,
- the key byte of the oldest record,
- the duration byte of the oldest record, where a read also retires that record,
- a fixed identification byte.

An active-low interrupt announces that press records are waiting. The control byte also commands a software shutdown and a high-impedance request for the external sense drive.

Top module: `keyev_recorder`

## Requirements
- R1: After reset every FIFO slot holds key byte 0xFF and duration 0, the FIFO is empty, irq_n is high and drv_hiz is low; reading address 1 returns 0xFF and address 2 returns 0x00 before any event.
- R2: Each accepted key_vld pulse appends one record holding key_code, and records are read back oldest first; a code equal to REL_CODE (default 0x00) marks a release, any other code a press.
- R3: The duration stored with a record is the number of tick pulses seen since the previous accepted event (or since reset), saturating at 127; bit 7 of the duration byte reads 0.
- R4: The duration counter restarts at 0 on every accepted event, even when a tick arrives in the same cycle.
- R5: reg_rdata is combinational from reg_addr: 0 = control/status, 1 = head key byte, 2 = head duration byte, 3 = identification byte.
- R6: A read of address 2 while the FIFO holds records retires the head record; the same read on an empty FIFO changes nothing.
- R7: The FIFO holds 8 records; an event arriving while it is full is dropped and sets a sticky overflow flag in control bit 1, which clears on the cycle after a read of address 0 unless another drop happens in that cycle.
- R8: irq_n goes low after a press record is stored and returns high as soon as the FIFO is empty; a release record alone does not pull it low.
- R9: While control bits 7:5 are all 1 (shutdown), key_vld is ignored, the duration counter holds its value and drv_hiz is high; control bit 4 set to 1 also drives drv_hiz high.
- R10: Control bits 7:4 are written through address 0 and read back; bits 3:2 read 0 and bit 0 reads 1 exactly when the FIFO is empty.
- R11: Address 3 returns the fixed value {7'b0, VARIANT}, which is 0x00 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | One-cycle strobe: key_code holds a new key state |
| key_code | input | 8 | Decoded key or release code |
| tick | input | 1 | Timebase pulse for duration counting |
| reg_addr | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe for the selected register |
| reg_wr | input | 1 | Write strobe (address 0 only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt: press records pending |
| drv_hiz | output | 1 | High-impedance request for the sense drive |

## Verification
The bench waits far longer than 127 ticks between events, so a counter that wraps instead of saturating stores a small value rather than 127. A tick and an event are made to coincide, which exposes a counter that lets the increment win over the restart. The FIFO is overfilled, which shows whether a design overwrites the oldest record, loses the sticky flag or clears it without a control read. Empty-FIFO reads check that a design does not move its pointers on an empty read or forget the preset contents. Events and ticks sent during shutdown catch a design that still records events or keeps counting.

// File: rtl/keyev_pkg.sv
package keyev_pkg;
  localparam int KEY_W = 8;
  localparam int DUR_W = 7;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic [DUR_W-1:0] dur;
  } keyev_rec_t;

  localparam int REC_W = $bits(keyev_rec_t);

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_KEY  = 2'd1,
    RA_DUR  = 2'd2,
    RA_ID   = 2'd3
  } keyev_addr_e;
endpackage

// File: rtl/keyev_durcnt.sv
module keyev_durcnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold,
  input  logic         clr,
  output logic [W-1:0] dur
);
  localparam logic [W-1:0] DMAX = '1;

  logic [W-1:0] dur_d;
  logic         dur_en;

  always_comb begin
    dur_d  = dur;
    dur_en = 1'b0;
    if (clr) begin
      dur_d  = '0;
      dur_en = 1'b1;
    end else if (tick && !hold && (dur != DMAX)) begin
      dur_d  = dur + 1'b1;
      dur_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dur <= '0;
    else if (dur_en) dur <= dur_d;
  end

  // R3
  dur_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dur == DMAX && !clr) |=> dur == DMAX);
  // R4
  dur_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dur == '0);
  // R9
  dur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(dur));
endmodule

// File: rtl/keyev_fifo.sv
module keyev_fifo #(
  parameter int             DEPTH  = 8,
  parameter int             W      = 15,
  parameter logic [W-1:0]   PRESET = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] LFULL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_d, rp_d;
  logic [LW-1:0] level_d;
  logic          push_ok, pop_ok;

  assign full    = (level == LFULL);
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  always_comb begin
    wp_d    = wp;
    rp_d    = rp;
    level_d = level;
    if (push_ok) wp_d = (wp == LAST) ? '0 : wp + 1'b1;
    if (pop_ok)  rp_d = (rp == LAST) ? '0 : rp + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   level_d = level + 1'b1;
      2'b01:   level_d = level - 1'b1;
      default: level_d = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp_d;
      rp    <= rp_d;
      level <= level_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[i] <= PRESET;
      else if (push_ok && wp == AW'(i))      mem[i] <= wdata;
    end
  end

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LFULL);
  // R7
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> level == LFULL);
  // R6
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/keyev_regs.sv
module keyev_regs #(
  parameter int         KW = 8,
  parameter int         DW = 7,
  parameter logic [7:0] ID = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          empty,
  input  logic [KW-1:0] head_key,
  input  logic [DW-1:0] head_dur,
  input  logic          drop,
  input  logic          press_push,
  output logic [7:0]    reg_rdata,
  output logic          shut,
  output logic          hiz,
  output logic          irq_n,
  output logic          pop_req
);
  import keyev_pkg::*;

  keyev_addr_e sel;
  logic [3:0]  ctl_q, ctl_d;
  logic        ctl_en;
  logic        ovf_q, ovf_d;
  logic        pend_q, pend_d;
  logic        ctl_rd;

  assign sel     = keyev_addr_e'(reg_addr);
  assign ctl_rd  = reg_rd && (sel == RA_CTRL);
  assign pop_req = reg_rd && (sel == RA_DUR);
  assign shut    = &ctl_q[3:1];
  assign hiz     = shut || ctl_q[0];
  assign irq_n   = !(pend_q && !empty);

  always_comb begin
    ctl_en = reg_wr && (sel == RA_CTRL);
    ctl_d  = reg_wdata[7:4];
    if (drop)        ovf_d = 1'b1;
    else if (ctl_rd) ovf_d = 1'b0;
    else             ovf_d = ovf_q;
    if (press_push)  pend_d = 1'b1;
    else if (empty)  pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      ovf_q  <= ovf_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    case (sel)
      RA_CTRL: reg_rdata = {ctl_q, 2'b00, ovf_q, empty};
      RA_KEY:  reg_rdata = 8'(head_key);
      RA_DUR:  reg_rdata = 8'(head_dur);
      default: reg_rdata = ID;
    endcase
  end

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
  // R7
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !drop) |=> !ovf_q);
  // R8
  irq_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_push |=> !irq_n);
endmodule

// File: rtl/keyev_recorder.sv
module keyev_recorder #(
  parameter int         DEPTH    = 8,
  parameter logic [7:0] REL_CODE = 8'h00,
  parameter bit         VARIANT  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_vld,
  input  logic [7:0] key_code,
  input  logic       tick,
  input  logic [1:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_n,
  output logic       drv_hiz
);
  import keyev_pkg::*;

  localparam int         LW     = $clog2(DEPTH + 1);
  localparam logic [7:0] ID_VAL = {7'b0, VARIANT};
  localparam keyev_rec_t PRESET = '{key: '1, dur: '0};

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic             shut, pop_req, full, empty;
  logic             ev, acc, drop, press_push;
  logic [DUR_W-1:0] dur;
  logic [LW-1:0]    level;
  keyev_rec_t       rec_in, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign ev         = key_vld && !shut;
  assign acc        = ev && !full;
  assign drop       = ev && full;
  assign press_push = acc && (key_code != REL_CODE);
  assign rec_in     = '{key: key_code, dur: dur};

  keyev_durcnt #(.W(DUR_W)) u_dur (
    .clk  (clk),
    .rst_n(rst_core_n),
    .tick (tick),
    .hold (shut),
    .clr  (ev),
    .dur  (dur)
  );

  keyev_fifo #(.DEPTH(DEPTH), .W(REC_W), .PRESET(PRESET)) u_fifo (
    .clk  (clk),
    .rst_n(rst_core_n),
    .push (ev),
    .pop  (pop_req),
    .wdata(rec_in),
    .head (head),
    .level(level),
    .full (full),
    .empty(empty)
  );

  keyev_regs #(.KW(KEY_W), .DW(DUR_W), .ID(ID_VAL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .empty     (empty),
    .head_key  (head.key),
    .head_dur  (head.dur),
    .drop      (drop),
    .press_push(press_push),
    .reg_rdata (reg_rdata),
    .shut      (shut),
    .hiz       (drv_hiz),
    .irq_n     (irq_n),
    .pop_req   (pop_req)
  );

  // R9
  shut_ignore_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (shut && !pop_req) |=> $stable(level));
  // R8
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (level == '0) |-> irq_n);
endmodule

// File: tb/sim_keyev_recorder.sv
module sim_keyev_recorder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_vld = 1'b0;
  logic [7:0] key_code = 8'h00;
  logic       tick = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_n, drv_hiz;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit armed = 1'b0;

  int mkey [8];
  int mdur [8];
  int wp, rp, cnt, dur, ovf, pend;
  logic [3:0] ctl;

  always #10 clk = ~clk;

  keyev_recorder u0 (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_code(key_code),
    .tick(tick), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n),
    .drv_hiz(drv_hiz)
  );

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      mkey[i] = 8'hFF;
      mdur[i] = 0;
    end
    wp = 0; rp = 0; cnt = 0; dur = 0; ovf = 0; pend = 0; ctl = 4'h0;
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    logic       exp_irq, exp_hiz;
    string      tag;
    case (reg_addr)
      2'd0: begin exp_rd = {ctl, 2'b00, ovf[0], (cnt == 0)}; tag = "R10/R7"; end
      2'd1: begin exp_rd = 8'(mkey[rp]); tag = "R2/R5"; end
      2'd2: begin exp_rd = 8'(mdur[rp]); tag = "R3/R5"; end
      default: begin exp_rd = 8'h00; tag = "R11"; end
    endcase
    exp_irq = !(pend != 0 && cnt > 0);
    exp_hiz = (ctl[3:1] == 3'b111) || ctl[0];
    vectors++;
    if (reg_rdata !== exp_rd) begin
      miscompares++;
      $display("FAIL %s addr %0d rdata actual %h expected %h", tag, reg_addr, reg_rdata, exp_rd);
    end
    if (irq_n !== exp_irq) begin
      miscompares++;
      $display("FAIL R8 irq_n actual %b expected %b", irq_n, exp_irq);
    end
    if (drv_hiz !== exp_hiz) begin
      miscompares++;
      $display("FAIL R9 drv_hiz actual %b expected %b", drv_hiz, exp_hiz);
    end
  endtask

  task automatic model_step(input bit v, input int c, input bit t,
                            input bit rd, input bit wr, input int a, input int wd);
    bit sd, ev, push, drop, pop, pp;
    int cnt0;
    sd   = (ctl[3:1] == 3'b111);
    ev   = v && !sd;
    push = ev && (cnt < 8);
    drop = ev && (cnt == 8);
    pop  = rd && (a == 2) && (cnt > 0);
    pp   = push && (c != 0);
    cnt0 = cnt;
    if (push) begin
      mkey[wp] = c;
      mdur[wp] = dur;
      wp = (wp + 1) % 8;
      cnt++;
    end
    if (pop) begin
      rp = (rp + 1) % 8;
      cnt--;
    end
    if (ev) dur = 0;
    else if (t && !sd && dur < 127) dur++;
    if (drop) ovf = 1;
    else if (rd && a == 0) ovf = 0;
    if (pp) pend = 1;
    else if (cnt0 == 0) pend = 0;
    if (wr && a == 0) ctl = 4'(wd >> 4);
  endtask

  task automatic cyc(input bit v, input int c, input bit t,
                     input bit rd, input bit wr, input int a, input int wd);
    @(negedge clk);
    key_vld = v; key_code = 8'(c); tick = t;
    reg_rd = rd; reg_wr = wr; reg_addr = 2'(a); reg_wdata = 8'(wd);
    #1;
    if (armed) compare();
    @(posedge clk);
    model_step(v, c, t, rd, wr, a, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic event_in(input int c);
    cyc(1, c, 0, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(input int a);
    cyc(0, 0, 0, 1, 0, a, 0);
  endtask
  task automatic wr_ctl(input int d);
    cyc(0, 0, 0, 0, 1, 0, d);
  endtask
  task automatic pop_one();
    rd_reg(1);
    rd_reg(2);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    armed = 1'b1;
    idle(3);
    // R1, R5, R11: preset contents, empty, identification byte
    rd_reg(0); rd_reg(1); rd_reg(2); rd_reg(3);
    // R2, R3: a press after 5 ticks and a release after 10 ticks
    ticks(5);
    event_in(8'h12);
    ticks(10);
    event_in(8'h00);
    rd_reg(0);
    pop_one();
    pop_one();
    // R6: reading address 2 on an empty FIFO changes nothing
    rd_reg(2); rd_reg(2); rd_reg(1); rd_reg(0);
    // R3: saturation after a long press
    ticks(140);
    event_in(8'h33);
    // R4: tick together with an event restarts the counter
    ticks(3);
    cyc(1, 8'h00, 1, 0, 0, 0, 0);
    ticks(2);
    cyc(1, 8'h44, 1, 0, 0, 0, 0);
    // R7: fill to eight records and overflow
    for (int i = 0; i < 7; i++) begin
      ticks(i + 1);
      event_in((i % 2 == 0) ? 0 : 8'h50 + i);
    end
    rd_reg(0);
    rd_reg(0);
    // R7: flag cleared by a control read
    rd_reg(0);
    // R8: drain, interrupt returns high when empty
    for (int i = 0; i < 8; i++) pop_one();
    rd_reg(0);
    // R8: a release record alone leaves irq_n high
    event_in(8'h00);
    rd_reg(0);
    pop_one();
    // R9: shutdown ignores events and holds the counter
    ticks(4);
    wr_ctl(8'hE0);
    rd_reg(0);
    ticks(6);
    event_in(8'h66);
    event_in(8'h00);
    rd_reg(0);
    wr_ctl(8'h00);
    ticks(2);
    event_in(8'h77);
    pop_one();
    // R9, R10: high-impedance bit alone, spare bits read 0
    wr_ctl(8'h1F);
    rd_reg(0);
    event_in(8'h21);
    wr_ctl(8'hA0);
    rd_reg(0);
    pop_one();
    wr_ctl(8'h00);
    rd_reg(0); rd_reg(3);
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule